// File: doc/BRIEF.md
# Programmable Parallel Port Bus Core

This block sits between a byte-wide processor bus and three 8-bit peripheral ports. Ports A and B are 8 bits wide. Port C is 8 bits wide and is split into an upper half and a lower half. Software configures the block through a control register. One control write either reprograms the whole port arrangement or sets or clears a single Port C bit. The top data bit of the written byte selects which of the two it does.

Ports are grouped in two. Group A holds Port A and the upper half of Port C. Group B holds Port B and the lower half of Port C. In basic mode each port or half-port is a plain input or a latched output. The handshaken modes are only decoded here: the mode value is passed on to neighbouring logic, and the group's pins are released to that logic. Each pad is modelled as an output value, an output enable and an input value. Bus strobes are sampled on the system clock. A write takes effect once, after its strobe is released.

Top module: `ppb_top`

## Requirements
- R1: `addr_i` selects the target of a read or write: 00 Port A, 01 Port B, 10 Port C, 11 control register.
- R2: While `cs_ni` is high, writes change nothing. `data_oe_o` is high only while both `cs_ni` and `rd_ni` are low.
- R3: A control register read returns 1 in bit 7 and the last mode byte written in bits 6..0.
- R4: After reset the control register reads 0x9B, every output enable is low, every output latch is 0 and both groups are in basic mode.
- R5: In basic mode the control bits set the direction, with 1 meaning input (enable low) and 0 meaning output: bit 4 for Port A, bit 3 for the upper half of Port C, bit 1 for Port B and bit 0 for the lower half of Port C.
- R6: Port outputs come from latches. Reading a port returns the latch value on output bits and the live input pin on input bits.
- R7: A mode-set write (bit 7 = 1) clears all three output latches and raises `mode_set_o` for one cycle.
- R8: A direct Port C write changes only the bits that belong to a basic-mode half configured as output.
- R9: A write with bit 7 = 0 sets or clears one Port C latch bit and leaves the control register unchanged. Bits 3..1 select the bit and bit 0 gives the value. This works in every mode and for every direction.
- R10: Bits 6..5 give the Group A mode on `grp_a_mode_o`: 00 gives 0 (basic), 01 gives 1 (strobed) and 1x gives 2 (bidirectional). Bit 2 gives the Group B mode on `grp_b_mode_o`. A group that is not in basic mode has all its output enables low, and a read of its Port C half returns the latch.
- R11: Each write pulse commits exactly once, on the release of `wr_ni`, however long the pulse lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Write data from the processor |
| data_o | output | 8 | Read data to the processor |
| data_oe_o | output | 1 | Read data bus drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A drive enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B drive enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C drive enables |
| grp_a_mode_o | output | 2 | Group A mode: 0 basic, 1 strobed, 2 bidirectional |
| grp_b_mode_o | output | 1 | Group B mode: 0 basic, 1 strobed |
| mode_set_o | output | 1 | One-cycle pulse after a mode-set write |

## Verification
A corrupted control register shows up immediately in two places: the output enables, and the control readback on the very next read. Because of that, every configuration is checked through both. A latch that misses a write, or one that a mode set fails to clear, shows up on the port outputs two clocks after the write strobe is released. An error in the direct Port C write mask shows up as a change in a Port C half that should have held its value. The bench sweeps all sixteen basic direction patterns, all eight set/clear bit positions and the handshaken mode codes.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int ADDR_W = 2;
  localparam int NPORT  = 3;
  localparam int SEL_W  = $clog2(PORT_W);

  localparam logic [ADDR_W-1:0] ADR_PA  = 2'b00;
  localparam logic [ADDR_W-1:0] ADR_PB  = 2'b01;
  localparam logic [ADDR_W-1:0] ADR_PC  = 2'b10;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'b11;

  // reset config: basic mode, every port input
  localparam logic [PORT_W-2:0] CTL_RST = 7'h1B;

  typedef enum logic [1:0] {
    GM_BASIC   = 2'd0,
    GM_STROBED = 2'd1,
    GM_BIDIR   = 2'd2
  } grp_mode_e;

  typedef struct packed {
    logic              cs_n;
    logic              wr_n;
    logic [ADDR_W-1:0] addr;
    logic [PORT_W-1:0] data;
  } bus_smp_t;
endpackage

// File: rtl/ppb_wr_edge.sv
module ppb_wr_edge
  import ppb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PORT_W-1:0] data_o
);
  localparam bus_smp_t SMP_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};

  bus_smp_t s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= SMP_IDLE;
      s2_q <= SMP_IDLE;
    end else begin
      s1_q <= '{cs_n: cs_ni, wr_n: wr_ni, addr: addr_i, data: data_i};
      s2_q <= s1_q;
    end
  end

  // commit on release, using the last sample taken while the strobe was low
  assign wr_stb_o = s1_q.wr_n & ~s2_q.wr_n & ~s2_q.cs_n;
  assign addr_o   = s2_q.addr;
  assign data_o   = s2_q.data;
endmodule

// File: rtl/ppb_cfg.sv
module ppb_cfg
  import ppb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-2:0] ctl_o,
  output logic              mode_set_o,
  output logic              mode_wr_o,
  output logic              bit_wr_o,
  output logic [1:0]        grp_a_mode_o,
  output logic              grp_b_mode_o,
  output logic [PORT_W-1:0] pa_oe_o,
  output logic [PORT_W-1:0] pb_oe_o,
  output logic [PORT_W-1:0] pc_oe_o,
  output logic [PORT_W-1:0] pc_basic_o
);
  logic [PORT_W-2:0] ctl_q;
  logic              mode_set_q;
  logic              ctl_hit;
  logic              basic_a, basic_b;
  grp_mode_e         mode_a;

  assign ctl_hit   = wr_stb_i && (addr_i == ADR_CTL);
  assign mode_wr_o = ctl_hit & data_i[PORT_W-1];
  assign bit_wr_o  = ctl_hit & ~data_i[PORT_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= CTL_RST;
      mode_set_q <= 1'b0;
    end else begin
      mode_set_q <= mode_wr_o;
      if (mode_wr_o) ctl_q <= data_i[PORT_W-2:0];
    end
  end

  always_comb begin
    if (ctl_q[6])      mode_a = GM_BIDIR;
    else if (ctl_q[5]) mode_a = GM_STROBED;
    else               mode_a = GM_BASIC;
  end

  assign basic_a = (mode_a == GM_BASIC);
  assign basic_b = ~ctl_q[2];

  assign pa_oe_o    = {PORT_W{basic_a & ~ctl_q[4]}};
  assign pb_oe_o    = {PORT_W{basic_b & ~ctl_q[1]}};
  assign pc_oe_o    = {{HALF_W{basic_a & ~ctl_q[3]}}, {HALF_W{basic_b & ~ctl_q[0]}}};
  assign pc_basic_o = {{HALF_W{basic_a}}, {HALF_W{basic_b}}};

  assign ctl_o        = ctl_q;
  assign mode_set_o   = mode_set_q;
  assign grp_a_mode_o = mode_a;
  assign grp_b_mode_o = ctl_q[2];
endmodule

// File: rtl/ppb_port_latch.sv
module ppb_port_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (clr_i) q <= '0;
    else if (wr_i)  q <= (q & ~mask_i) | (data_i & mask_i);
  end

  assign q_o = q;
endmodule

// File: rtl/ppb_top.sv
module ppb_top
  import ppb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o,
  output logic [1:0]        grp_a_mode_o,
  output logic              grp_b_mode_o,
  output logic              mode_set_o
);
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [PORT_W-1:0] wr_data;
  logic [PORT_W-2:0] ctl;
  logic              mode_wr, bit_wr;
  logic [PORT_W-1:0] pc_basic;
  logic [PORT_W-1:0] bit_mask;

  logic [NPORT-1:0]             lat_wr;
  logic [NPORT-1:0][PORT_W-1:0] lat_mask, lat_data, lat_q;
  logic [NPORT-1:0][PORT_W-1:0] pin_i, pin_oe, rd_view;

  ppb_wr_edge u_edge (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .addr_i, .data_i,
    .wr_stb_o(wr_stb), .addr_o(wr_addr), .data_o(wr_data)
  );

  ppb_cfg u_cfg (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .addr_i(wr_addr), .data_i(wr_data),
    .ctl_o(ctl), .mode_set_o(mode_set_o), .mode_wr_o(mode_wr), .bit_wr_o(bit_wr),
    .grp_a_mode_o(grp_a_mode_o), .grp_b_mode_o(grp_b_mode_o),
    .pa_oe_o(pa_oe_o), .pb_oe_o(pb_oe_o), .pc_oe_o(pc_oe_o), .pc_basic_o(pc_basic)
  );

  always_comb begin
    bit_mask = '0;
    bit_mask[wr_data[SEL_W:1]] = 1'b1;
  end

  // Port A / B: full-byte writes; Port C: masked direct write or single-bit command
  assign lat_wr[0]   = wr_stb && (wr_addr == ADR_PA);
  assign lat_wr[1]   = wr_stb && (wr_addr == ADR_PB);
  assign lat_wr[2]   = (wr_stb && (wr_addr == ADR_PC)) || bit_wr;
  assign lat_mask[0] = '1;
  assign lat_mask[1] = '1;
  assign lat_mask[2] = bit_wr ? bit_mask : pc_oe_o;
  assign lat_data[0] = wr_data;
  assign lat_data[1] = wr_data;
  assign lat_data[2] = bit_wr ? {PORT_W{wr_data[0]}} : wr_data;

  assign pin_i  = {pc_i, pb_i, pa_i};
  assign pin_oe = {pc_oe_o, pb_oe_o, pa_oe_o};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ppb_port_latch #(.W(PORT_W)) u_lat (
      .clk_i, .rst_ni,
      .clr_i (mode_wr),
      .wr_i  (lat_wr[p]),
      .mask_i(lat_mask[p]),
      .data_i(lat_data[p]),
      .q_o   (lat_q[p])
    );
    assign rd_view[p] = (pin_oe[p] & lat_q[p]) | (~pin_oe[p] & pin_i[p]);
  end

  assign pa_o = lat_q[0];
  assign pb_o = lat_q[1];
  assign pc_o = lat_q[2];

  always_comb begin
    unique case (addr_i)
      ADR_PA:  data_o = rd_view[0];
      ADR_PB:  data_o = rd_view[1];
      ADR_PC:  data_o = (pc_basic & rd_view[2]) | (~pc_basic & lat_q[2]);
      default: data_o = {1'b1, ctl};
    endcase
  end

  assign data_oe_o = ~cs_ni & ~rd_ni;
endmodule

// File: rtl/ppb_top_chk.sv
module ppb_top_chk
  import ppb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PORT_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [PORT_W-1:0] pa_o,
  input logic [PORT_W-1:0] pa_oe_o,
  input logic [PORT_W-1:0] pb_o,
  input logic [PORT_W-1:0] pb_oe_o,
  input logic [PORT_W-1:0] pc_o,
  input logic [PORT_W-1:0] pc_oe_o,
  input logic [1:0]        grp_a_mode_o,
  input logic              grp_b_mode_o,
  input logic              mode_set_o
);
  // R2
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> !data_oe_o);

  // R3
  ctl_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_CTL) |-> data_o[PORT_W-1]);

  // R7
  mode_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set_o |-> (pa_o == '0 && pb_o == '0 && pc_o == '0));

  // R5
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o)) |-> mode_set_o);

  // R10
  hs_a_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_a_mode_o != 2'd0) |-> (pa_oe_o == '0 && pc_oe_o[PORT_W-1:HALF_W] == '0));

  // R10
  hs_b_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_b_mode_o |-> (pb_oe_o == '0 && pc_oe_o[HALF_W-1:0] == '0));

  // R11
  one_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set_o |=> !mode_set_o);
endmodule

bind ppb_top ppb_top_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .addr_i(addr_i),
  .data_o(data_o), .data_oe_o(data_oe_o),
  .pa_o(pa_o), .pa_oe_o(pa_oe_o), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
  .pc_o(pc_o), .pc_oe_o(pc_oe_o),
  .grp_a_mode_o(grp_a_mode_o), .grp_b_mode_o(grp_b_mode_o), .mode_set_o(mode_set_o)
);

// File: tb/ppb_top_tb_top.sv
module ppb_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       doe;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;
  logic [1:0] gam;
  logic       gbm, mset;

  int n_run = 0, n_fail = 0, ms_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && mset) ms_cnt++;

  ppb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe),
    .grp_a_mode_o(gam), .grp_b_mode_o(gbm), .mode_set_o(mset)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic bwr(logic [1:0] a, logic [7:0] d, logic cs = 1'b0, int len = 2);
    @(negedge clk);
    cs_n = cs; addr = a; din = d; wr_n = 1'b0;
    repeat (len) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic brd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = dout;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    brd(2'b11, r);
    chk("R4 ctl reset", r, 8'h9B);
    chk("R4 oe reset", pa_oe | pb_oe | pc_oe, 8'h00);
    chk("R4 latch reset", pa_o | pb_o | pc_o, 8'h00);
    chk("R4 mode reset", {5'd0, gbm, gam}, 8'h00);

    // R2 bus gating
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R2 oe cs high", {7'd0, doe}, 8'h00);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk("R2 oe rd high", {7'd0, doe}, 8'h00);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    chk("R2 oe active", {7'd0, doe}, 8'h01);
    rd_n = 1'b1; cs_n = 1'b1;
    bwr(2'b11, 8'h80);
    bwr(2'b00, 8'h77, 1'b1);
    chk("R2 write ignored cs high", pa_o, 8'h00);
    bwr(2'b11, 8'h92, 1'b1);
    brd(2'b11, r);
    chk("R2 ctl ignored cs high", r, 8'h80);

    // R5 R6 R1 R3 R8: sweep all basic direction patterns
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic ia, icu, ib, icl;
      logic [7:0] w, va, vb, vc, cmask;
      ia = cfg[3]; icu = cfg[2]; ib = cfg[1]; icl = cfg[0];
      w = 8'h80 | (8'(ia) << 4) | (8'(icu) << 3) | (8'(ib) << 1) | 8'(icl);
      bwr(2'b11, w);
      brd(2'b11, r);
      chk("R3 ctl readback", r, w);
      chk("R5 pa dir", pa_oe, {8{~ia}});
      chk("R5 pb dir", pb_oe, {8{~ib}});
      chk("R5 pc dir", pc_oe, {{4{~icu}}, {4{~icl}}});
      va = 8'h5A ^ 8'(cfg); vb = 8'hA5 ^ 8'(cfg * 3); vc = 8'h3C ^ 8'(cfg * 5);
      pa_i = 8'hC3 ^ 8'(cfg); pb_i = 8'h96 ^ 8'(cfg); pc_i = 8'h69 ^ 8'(cfg);
      bwr(2'b00, va); bwr(2'b01, vb); bwr(2'b10, vc);
      cmask = {{4{~icu}}, {4{~icl}}};
      chk("R1 pa latch", pa_o, va);
      chk("R1 pb latch", pb_o, vb);
      chk("R8 pc masked write", pc_o, vc & cmask);
      brd(2'b00, r); chk("R6 pa read", r, ia ? pa_i : va);
      brd(2'b01, r); chk("R6 pb read", r, ib ? pb_i : vb);
      brd(2'b10, r); chk("R6 pc read", r, (cmask & vc) | (~cmask & pc_i));
    end

    // R7 mode set clears latches
    bwr(2'b11, 8'h80);
    bwr(2'b00, 8'hFF); bwr(2'b01, 8'hEE); bwr(2'b10, 8'hDD);
    bwr(2'b11, 8'h80);
    chk("R7 clear", pa_o | pb_o | pc_o, 8'h00);

    // R11 long pulse commits once
    ms_cnt = 0;
    bwr(2'b11, 8'h80, 1'b0, 20);
    chk("R11 single commit", 8'(ms_cnt), 8'd1);

    // R9 single bit set/clear across all positions
    begin
      logic [7:0] e = 8'h00;
      for (int b = 0; b < 8; b++) begin
        bwr(2'b11, 8'((b << 1) | 1));
        e[b] = 1'b1;
        chk("R9 bit set", pc_o, e);
      end
      for (int b = 0; b < 8; b += 2) begin
        bwr(2'b11, 8'(b << 1));
        e[b] = 1'b0;
        chk("R9 bit clear", pc_o, e);
      end
      brd(2'b11, r);
      chk("R9 ctl untouched", r, 8'h80);
    end
    // R9 on an input half
    bwr(2'b11, 8'h89);
    bwr(2'b11, 8'h0B);
    chk("R9 bit on input half", pc_o, 8'h20);

    // R10 handshake modes
    bwr(2'b11, 8'hC4);
    chk("R10 grp a bidir", {6'd0, gam}, 8'h02);
    chk("R10 grp b strobed", {7'd0, gbm}, 8'h01);
    chk("R10 oe released", pa_oe | pb_oe | pc_oe, 8'h00);
    bwr(2'b11, 8'hE0);
    chk("R10 grp a 11 bidir", {6'd0, gam}, 8'h02);
    bwr(2'b11, 8'hA0);
    chk("R10 grp a strobed", {6'd0, gam}, 8'h01);
    chk("R10 grp b basic", {7'd0, gbm}, 8'h00);
    chk("R10 pc oe", pc_oe, 8'h0F);
    bwr(2'b10, 8'hFF);
    chk("R8 hs half protected", pc_o, 8'h0F);
    bwr(2'b11, 8'h0D);
    chk("R9 bit in hs half", pc_o, 8'h4F);
    pc_i = 8'h00;
    brd(2'b10, r);
    chk("R10 pc read hs half", r, 8'h4F);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule